// File: doc/BRIEF.md
# Parity-Framed Manchester Word Transmitter

This block turns 32-bit memory words into a serial, Manchester-coded stream that drives a load modulator. Each word is sent as a 45-bit frame: four data bytes, each followed by its own even-parity bit, then one byte of column parity and a closing zero. A word marked read-protected by the memory is sent as a frame of all zeros. The block fetches words itself through a simple address/data port and plays them in a loop over a configured address range.

Before every word a listen window is produced by an external pattern generator. The block starts that generator with a one-cycle pulse and waits for its completion strobe. When a pass over the range starts, whether after reset, after a restart or on wrap-around, two windows are requested instead of one. A bit lasts 64 or 32 clocks of the carrier-derived clock, selected per word. With 64 clocks per bit and a 320-clock window, one word plus its window fills 3200 clocks. A stop input lets the surrounding logic freeze the stream cleanly at the end of the bit in progress.

Top module: `mwt_word_tx`

## Requirements
- R1: While `rst` is high, `mod_out` and `liw_start` are 0 and `fetch_addr` is 0.
- R2: Frame positions 0..35 (position 0 sent first) carry data byte k (bits 8k..8k+7, LSB first) at positions 9k..9k+7 and its even parity at position 9k+8.
- R3: Frame positions 36..43 carry column parity, position 36+i being the XOR of data bits i, i+8, i+16 and i+24; position 44 is always 0.
- R4: When `fetch_prot` is 1 for the word being sent, all 45 frame bits are 0.
- R5: Each bit lasts 64 clocks when `rate_fast` is 0 and 32 clocks when it is 1 (sampled when the word starts). A 1 is sent as `mod_out` low for the first half and high for the second; a 0 is sent high then low. `mod_out` returns to 0 the clock after the last bit.
- R6: Words are fetched in order from `first_addr` up to `last_addr`, then from `first_addr` again; `fetch_addr` holds the address of the word being sent. The range is taken from the inputs when a pass starts.
- R7: Exactly one listen window precedes each word, except the first word of a pass, which is preceded by two.
- R8: When `first_addr` equals `last_addr`, that word repeats and each repetition is preceded by two windows.
- R9: A range is invalid if either address exceeds 33 or `first_addr` exceeds `last_addr`; an invalid range sends only the word at `first_addr`, repeatedly.
- R10: When `stop` is high at the end of a bit, transmission ends after that bit, `mod_out` stays 0 and no window is requested while `stop` stays high; releasing it restarts a pass with two windows and the first word.
- R11: `liw_start` is a one-clock pulse; the first half of bit 0 appears on `mod_out` after the second rising edge following the edge at which `liw_done` is sampled high for the last window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier-derived bit clock |
| rst | input | 1 | Synchronous active-high reset |
| stop | input | 1 | Halt at next bit boundary while high |
| rate_fast | input | 1 | 1 selects 32 clocks per bit, 0 selects 64 |
| first_addr | input | 8 | First address of the range |
| last_addr | input | 8 | Last address of the range |
| fetch_addr | output | 8 | Address of the word being fetched and sent |
| fetch_data | input | 32 | Word at `fetch_addr` |
| fetch_prot | input | 1 | Word at `fetch_addr` is read-protected |
| liw_start | output | 1 | Pulse asking the pattern generator for a window |
| liw_done | input | 1 | Pulse from the pattern generator: window finished |
| mod_out | output | 1 | Manchester-coded modulator drive |

## Verification
The assertions assume that `liw_done` is raised only while a requested window is pending and never in the same clock as `liw_start`, and that `fetch_data` and `fetch_prot` are stable from the address change to the start of the frame. The bench's pattern generator raises `liw_done` a fixed number of clocks after each `liw_start`, holds it for one clock, and its memory model answers combinationally from `fetch_addr`. Range and rate inputs are changed only during reset, and `stop` is toggled on clock falling edges mid-word and held for many bit periods.

// File: rtl/mwt_pkg.sv
package mwt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LIW  = 2'd1,
    ST_WORD = 2'd2
  } tx_state_t;
endpackage

// File: rtl/mwt_frame_pack.sv
module mwt_frame_pack #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 4,
  localparam int WORD_W = BYTE_W * NBYTES,
  localparam int FRAME_LEN = NBYTES * (BYTE_W + 1) + BYTE_W + 1
) (
  input  logic [WORD_W-1:0]    word_in,
  input  logic                 prot_in,
  output logic [FRAME_LEN-1:0] frame_out
);
  localparam int COL_BASE = NBYTES * (BYTE_W + 1);

  logic [FRAME_LEN-1:0] raw;
  logic [BYTE_W-1:0]    colp;

  // Rows: data byte followed by its even parity, LSB first
  for (genvar r = 0; r < NBYTES; r++) begin : g_row
    assign raw[r*(BYTE_W+1) +: BYTE_W] = word_in[r*BYTE_W +: BYTE_W];
    assign raw[r*(BYTE_W+1) + BYTE_W]  = ^word_in[r*BYTE_W +: BYTE_W];
  end

  always_comb begin
    colp = '0;
    for (int r = 0; r < NBYTES; r++) begin
      colp = colp ^ word_in[r*BYTE_W +: BYTE_W];
    end
  end

  assign raw[COL_BASE +: BYTE_W] = colp;
  assign raw[FRAME_LEN-1]        = 1'b0;

  assign frame_out = prot_in ? '0 : raw;
endmodule

// File: rtl/mwt_addr_seq.sv
module mwt_addr_seq #(
  parameter int ADDR_W   = 8,
  parameter int MAX_ADDR = 33
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              advance,
  input  logic [ADDR_W-1:0] first_in,
  input  logic [ADDR_W-1:0] last_in,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              at_last
);
  localparam logic [ADDR_W-1:0] MAX_A = ADDR_W'(MAX_ADDR);

  logic [ADDR_W-1:0] first_l, last_l, last_eff;
  logic              rng_ok;

  assign rng_ok   = (first_in <= MAX_A) && (last_in <= MAX_A) && (first_in <= last_in);
  assign last_eff = rng_ok ? last_in : first_in;
  assign at_last  = (cur_addr == last_l);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      first_l  <= '0;
      last_l   <= '0;
    end else if (load || (advance && at_last)) begin
      cur_addr <= first_in;
      first_l  <= first_in;
      last_l   <= last_eff;
    end else if (advance) begin
      cur_addr <= cur_addr + 1'b1;
    end
  end

  // R6: the word address never leaves the latched range
  assert_addr_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    (cur_addr >= first_l) && (cur_addr <= last_l));
endmodule

// File: rtl/mwt_manch_enc.sv
module mwt_manch_enc #(
  parameter int LEN      = 45,
  parameter int SLOW_BIT = 64,
  parameter int FAST_BIT = 32,
  localparam int CNT_W   = $clog2(SLOW_BIT),
  localparam int IDX_W   = $clog2(LEN)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           fast,
  input  logic           stop,
  input  logic [LEN-1:0] frame,
  output logic           busy,
  output logic           done,
  output logic           abort,
  output logic           mod_out
);
  localparam logic [CNT_W-1:0] SLOW_M1   = CNT_W'(SLOW_BIT - 1);
  localparam logic [CNT_W-1:0] FAST_M1   = CNT_W'(FAST_BIT - 1);
  localparam logic [CNT_W-1:0] SLOW_HALF = CNT_W'(SLOW_BIT / 2);
  localparam logic [CNT_W-1:0] FAST_HALF = CNT_W'(FAST_BIT / 2);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(LEN - 1);

  logic [LEN-1:0]   shreg;
  logic [CNT_W-1:0] cnt, len_m1, half;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      abort   <= 1'b0;
      mod_out <= 1'b0;
      shreg   <= '0;
      cnt     <= '0;
      len_m1  <= SLOW_M1;
      half    <= SLOW_HALF;
      idx     <= '0;
    end else begin
      done  <= 1'b0;
      abort <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        shreg   <= frame;
        cnt     <= '0;
        idx     <= '0;
        len_m1  <= fast ? FAST_M1 : SLOW_M1;
        half    <= fast ? FAST_HALF : SLOW_HALF;
        mod_out <= 1'b0;
      end else if (busy) begin
        // a one goes low then high, a zero high then low
        mod_out <= (cnt < half) ? ~shreg[0] : shreg[0];
        if (cnt == len_m1) begin
          cnt <= '0;
          if (idx == LAST_IDX) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else if (stop) begin
            busy  <= 1'b0;
            abort <= 1'b1;
          end else begin
            shreg <= shreg >> 1;
            idx   <= idx + 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        mod_out <= 1'b0;
      end
    end
  end

  // R5: the level flips at every half-bit point
  assert_mid_flip_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && (cnt == half)) |=> (mod_out != $past(mod_out)));

  // R10: the modulator stays quiet while nothing is being sent
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> !mod_out);
endmodule

// File: rtl/mwt_word_tx.sv
module mwt_word_tx #(
  parameter int ADDR_W   = 8,
  parameter int MAX_ADDR = 33,
  parameter int BYTE_W   = 8,
  parameter int NBYTES   = 4,
  parameter int SLOW_BIT = 64,
  parameter int FAST_BIT = 32,
  localparam int WORD_W    = BYTE_W * NBYTES,
  localparam int FRAME_LEN = NBYTES * (BYTE_W + 1) + BYTE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop,
  input  logic              rate_fast,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [ADDR_W-1:0] last_addr,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic [WORD_W-1:0] fetch_data,
  input  logic              fetch_prot,
  output logic              liw_start,
  input  logic              liw_done,
  output logic              mod_out
);
  import mwt_pkg::*;

  tx_state_t            state;
  logic                 liw_two;
  logic                 enc_start, enc_busy, enc_done, enc_abort;
  logic                 load_range, at_last;
  logic [FRAME_LEN-1:0] frame;

  assign load_range = (state == ST_IDLE) && !stop;
  assign enc_start  = (state == ST_LIW) && liw_done && !liw_two && !stop;

  mwt_frame_pack #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) pack_i (
    .word_in   (fetch_data),
    .prot_in   (fetch_prot),
    .frame_out (frame)
  );

  mwt_addr_seq #(.ADDR_W(ADDR_W), .MAX_ADDR(MAX_ADDR)) seq_i (
    .clk      (clk),
    .rst      (rst),
    .load     (load_range),
    .advance  (enc_done),
    .first_in (first_addr),
    .last_in  (last_addr),
    .cur_addr (fetch_addr),
    .at_last  (at_last)
  );

  mwt_manch_enc #(.LEN(FRAME_LEN), .SLOW_BIT(SLOW_BIT), .FAST_BIT(FAST_BIT)) enc_i (
    .clk     (clk),
    .rst     (rst),
    .start   (enc_start),
    .fast    (rate_fast),
    .stop    (stop),
    .frame   (frame),
    .busy    (enc_busy),
    .done    (enc_done),
    .abort   (enc_abort),
    .mod_out (mod_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      liw_two   <= 1'b0;
      liw_start <= 1'b0;
    end else begin
      liw_start <= 1'b0;
      unique case (state)
        ST_IDLE: if (!stop) begin
          state     <= ST_LIW;
          liw_two   <= 1'b1;
          liw_start <= 1'b1;
        end
        ST_LIW: begin
          if (stop) begin
            state <= ST_IDLE;
          end else if (liw_done) begin
            if (liw_two) begin
              liw_two   <= 1'b0;
              liw_start <= 1'b1;
            end else begin
              state <= ST_WORD;
            end
          end
        end
        ST_WORD: begin
          if (enc_abort) begin
            state <= ST_IDLE;
          end else if (enc_done) begin
            if (stop) begin
              state <= ST_IDLE;
            end else begin
              state     <= ST_LIW;
              liw_two   <= at_last;
              liw_start <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: a window is never requested while a frame is on the air
  assert_liw_not_in_word_R7: assert property (@(posedge clk) disable iff (rst)
    liw_start |-> !enc_busy);

  // R11: a frame only begins right after a completed window
  assert_frame_after_liw_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(enc_busy) |-> $past(liw_done));
endmodule

// File: tb/mwt_word_tx_tb_top.sv
module mwt_word_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LIW_CYC    = 20;
  localparam int SLOW_L     = 64;
  localparam int FAST_L     = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stop = 1'b0;
  logic        rate_fast = 1'b0;
  logic [7:0]  first_addr = '0;
  logic [7:0]  last_addr = '0;
  logic [7:0]  fetch_addr;
  logic [31:0] fetch_data;
  logic        fetch_prot;
  logic        liw_start;
  logic        liw_done = 1'b0;
  logic        mod_out;
  logic [63:0] prot_mask = '0;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [7:0] a);
    return (32'h9E37_79B9 * ({24'd0, a} + 32'd1)) ^ 32'h5A5A_0F0F;
  endfunction

  assign fetch_data = mem_word(fetch_addr);
  assign fetch_prot = prot_mask[fetch_addr[5:0]];

  mwt_word_tx dut_i (
    .clk(clk), .rst(rst), .stop(stop), .rate_fast(rate_fast),
    .first_addr(first_addr), .last_addr(last_addr),
    .fetch_addr(fetch_addr), .fetch_data(fetch_data), .fetch_prot(fetch_prot),
    .liw_start(liw_start), .liw_done(liw_done), .mod_out(mod_out)
  );

  function automatic logic [44:0] ref_frame(input logic [31:0] d, input logic p);
    logic [44:0] f;
    int k;
    f = '0;
    k = 0;
    if (p) return f;
    for (int by = 0; by < 4; by++) begin
      logic par;
      par = 1'b0;
      for (int bi = 0; bi < 8; bi++) begin
        f[k] = d[by*8+bi];
        par  = par ^ d[by*8+bi];
        k++;
      end
      f[k] = par;
      k++;
    end
    for (int i = 0; i < 8; i++) begin
      f[k] = d[i] ^ d[i+8] ^ d[i+16] ^ d[i+24];
      k++;
    end
    f[44] = 1'b0;
    return f;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  task automatic do_reset(input logic [7:0] f, input logic [7:0] l, input logic fast);
    @(negedge clk);
    rst = 1'b1;
    stop = 1'b0;
    liw_done = 1'b0;
    first_addr = f;
    last_addr = l;
    rate_fast = fast;
    repeat (3) @(negedge clk);
    check(mod_out === 1'b0, "R1", "mod_out in reset", {63'd0, mod_out}, 64'd0);
    check(liw_start === 1'b0, "R1", "liw_start in reset", {63'd0, liw_start}, 64'd0);
    check(fetch_addr === 8'd0, "R1", "fetch_addr in reset", {56'd0, fetch_addr}, 64'd0);
    rst = 1'b0;
  endtask

  // Waits for a window request, serves it and any that follow; returns the count
  task automatic serve_liws(output int n);
    bit got, more;
    int t;
    n = 0;
    got = liw_start;
    t = 0;
    while (!got && t < 8000) begin
      @(negedge clk);
      got = liw_start;
      t++;
    end
    if (!got) begin
      check(1'b0, "R7", "no window request", 64'd0, 64'd1);
      return;
    end
    more = 1'b1;
    while (more) begin
      n++;
      repeat (LIW_CYC) @(negedge clk);
      liw_done = 1'b1;
      @(negedge clk);
      liw_done = 1'b0;
      more = liw_start;
    end
  endtask

  task automatic capture(input int L, output logic [44:0] got, output int merr);
    logic f0, fh;
    merr = 0;
    got = '0;
    f0 = 1'b0;
    fh = 1'b0;
    for (int c = 1; c <= 45*L; c++) begin
      int off, b;
      @(negedge clk);
      off = (c-1) % L;
      b = (c-1) / L;
      if (off == 0) f0 = mod_out;
      if (off == L/2 - 1) fh = mod_out;
      if (off == L/2) begin
        if (f0 !== fh || fh === mod_out) merr++;
        got[b] = mod_out;
      end
    end
  endtask

  task automatic expect_word(input int exp_liws, input logic [7:0] exp_addr,
                             input int L, input string tag);
    int n, merr;
    logic [44:0] got, exp;
    logic p;
    serve_liws(n);
    check(n == exp_liws, "R7", {tag, " window count"}, 64'(n), 64'(exp_liws));
    check(fetch_addr === exp_addr, "R6", {tag, " word address"}, {56'd0, fetch_addr}, {56'd0, exp_addr});
    p = prot_mask[exp_addr[5:0]];
    exp = ref_frame(mem_word(exp_addr), p);
    capture(L, got, merr);
    check(merr == 0, "R5", {tag, " manchester shape"}, 64'(merr), 64'd0);
    check(got[35:0] === exp[35:0], "R2", {tag, " data rows"}, {28'd0, got[35:0]}, {28'd0, exp[35:0]});
    check(got[44:36] === exp[44:36], "R3", {tag, " column parity and stop"}, {55'd0, got[44:36]}, {55'd0, exp[44:36]});
    if (p) check(got === 45'd0, "R4", {tag, " protected frame"}, {19'd0, got}, 64'd0);
    @(negedge clk);
    check(mod_out === 1'b0, "R5", {tag, " quiet after frame"}, {63'd0, mod_out}, 64'd0);
  endtask

  // Range loop at 64 clocks per bit, with one protected word
  task automatic test_range_slow();
    prot_mask = '0;
    prot_mask[4] = 1'b1;
    do_reset(8'd3, 8'd5, 1'b0);
    expect_word(2, 8'd3, SLOW_L, "R6 slow w3");
    expect_word(1, 8'd4, SLOW_L, "R4 slow w4");
    expect_word(1, 8'd5, SLOW_L, "R6 slow w5");
    expect_word(2, 8'd3, SLOW_L, "R7 wrap w3");
  endtask

  task automatic test_equal_fast();
    prot_mask = '0;
    do_reset(8'd7, 8'd7, 1'b1);
    expect_word(2, 8'd7, FAST_L, "R8 repeat a");
    expect_word(2, 8'd7, FAST_L, "R8 repeat b");
  endtask

  task automatic test_invalid();
    prot_mask = '0;
    do_reset(8'd10, 8'd2, 1'b1);
    expect_word(2, 8'd10, FAST_L, "R9 reversed a");
    expect_word(2, 8'd10, FAST_L, "R9 reversed b");
    do_reset(8'd5, 8'd40, 1'b1);
    expect_word(2, 8'd5, FAST_L, "R9 high last a");
    expect_word(2, 8'd5, FAST_L, "R9 high last b");
  endtask

  task automatic test_top_of_range();
    prot_mask = '0;
    do_reset(8'd32, 8'd33, 1'b1);
    expect_word(2, 8'd32, FAST_L, "R6 edge w32");
    expect_word(1, 8'd33, FAST_L, "R6 edge w33");
    expect_word(2, 8'd32, FAST_L, "R6 edge wrap");
  endtask

  task automatic test_stop();
    int n, zbad, lbad;
    logic [44:0] exp;
    prot_mask = '0;
    do_reset(8'd6, 8'd8, 1'b1);
    expect_word(2, 8'd6, FAST_L, "R10 pre-stop");
    serve_liws(n);
    check(n == 1, "R7", "R10 window before w7", 64'(n), 64'd1);
    exp = ref_frame(mem_word(8'd7), 1'b0);
    zbad = 0;
    for (int c = 1; c <= 6*FAST_L; c++) begin
      @(negedge clk);
      if (c == 3*FAST_L + 11) stop = 1'b1;
      if (c == 3*FAST_L + FAST_L/2 + 1)
        check(mod_out === exp[3], "R10", "bit in progress finishes", {63'd0, mod_out}, {63'd0, exp[3]});
      if (c == 4*FAST_L)
        check(mod_out === exp[3], "R10", "last half kept", {63'd0, mod_out}, {63'd0, exp[3]});
      if (c > 4*FAST_L && mod_out !== 1'b0) zbad++;
    end
    check(zbad == 0, "R10", "quiet after stop", 64'(zbad), 64'd0);
    lbad = 0;
    repeat (300) begin
      @(negedge clk);
      if (liw_start !== 1'b0 || mod_out !== 1'b0) lbad++;
    end
    check(lbad == 0, "R10", "no activity while stopped", 64'(lbad), 64'd0);
    stop = 1'b0;
    expect_word(2, 8'd6, FAST_L, "R10 restart");
  endtask

  // R11: first half of bit 0 timing relative to liw_done
  task automatic test_handshake_timing();
    int n;
    logic [44:0] exp;
    prot_mask = '0;
    do_reset(8'd9, 8'd9, 1'b1);
    serve_liws(n);
    exp = ref_frame(mem_word(8'd9), 1'b0);
    check(mod_out === 1'b0, "R11", "no bit before second edge", {63'd0, mod_out}, 64'd0);
    @(negedge clk);
    check(mod_out === ~exp[0], "R11", "bit 0 first half", {63'd0, mod_out}, {63'd0, ~exp[0]});
    check(liw_start === 1'b0, "R11", "start is a single pulse", {63'd0, liw_start}, 64'd0);
  endtask

  initial begin
    test_range_slow();
    test_equal_fast();
    test_invalid();
    test_top_of_range();
    test_stop();
    test_handshake_timing();
    report();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run did not finish", 64'd0, 64'd1);
    report();
    $finish;
  end
endmodule